// File: doc/BRIEF.md
# Reset Supervisor with Fault Capture

The block produces an active-high system reset for a chip from three sources: three low-voltage flags (one per supply rail, already synchronised to the clock), a manual-reset input, and a watchdog that the host must service with a kick pulse. When every fault source has cleared, reset stays asserted for a release delay chosen by a two-bit power-up select. The watchdog period is chosen by a second two-bit select, and one of its four codes turns the watchdog off. All delays and periods are parameters counted in clock cycles.

Each cause of reset sets a sticky bit in a five-bit cause register. The register is always visible on a byte-wide read port. The host rewrites it through a small framed write port. A frame begins with a start strobe that carries a four-bit device code and an eight-bit address, carries zero or more data-byte strobes, and ends with a stop strobe. The register is replaced only by a well-formed single-byte frame addressed to it. No write-enable step is needed first.

Top module: `reset_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is 1 and `fault_rd` reads 0. After `rst_n` rises, `sys_rst` stays 1 for exactly the release delay picked by `pup_sel`, counted in clock cycles: 00 gives DLY_SEL0, 01 gives DLY_SEL1, 10 gives DLY_SEL2 and 11 gives DLY_SEL3.
- R2: While any bit of `lv_flag` is 1, `sys_rst` is held at 1. The release delay starts only in the cycle after the last flag clears.
- R3: While `mr_in` is 1, `sys_rst` is held at 1. The release delay starts after `mr_in` clears.
- R4: With reset released, a watchdog counts clock cycles. If no `wd_kick` arrives within the period picked by `wd_sel`, `sys_rst` rises when the count runs out. The codes are 00 for WD_SEL0, 01 for WD_SEL1 and 10 for WD_SEL2.
- R5: A `wd_kick` pulse restarts the watchdog count from zero.
- R6: After a watchdog timeout, reset is held for the selected release delay. The watchdog then starts counting again from zero.
- R7: `fault_rd` uses this layout: bit 7 is set by `lv_flag[0]`, bit 6 by `lv_flag[1]`, bit 5 by `lv_flag[2]`, bit 4 by a watchdog timeout and bit 3 by `mr_in`. Bits 2..0 always read 0. A bit is set in the cycle after its source is active, and it stays set until it is rewritten.
- R8: A frame with device code 4'b1011, address 8'hFF and exactly one data byte loads bits 7..3 of that byte into the register on its stop strobe. A frame with no data byte, with two or more data bytes, or with another code or address leaves the register unchanged. A source that is active in the same cycle as the load still sets its bit.
- R9: With `wd_sel` = 11 the watchdog never causes a reset, whether or not kicks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| lv_flag | input | 3 | Synchronised low-voltage flags, one per rail, active high |
| mr_in | input | 1 | Manual reset request, active high |
| wd_kick | input | 1 | Watchdog service pulse |
| pup_sel | input | 2 | Release delay select |
| wd_sel | input | 2 | Watchdog period select (11 = off) |
| bus_start | input | 1 | Frame start strobe; latches device code and address |
| bus_dev | input | 4 | Device code of the frame |
| bus_addr | input | 8 | Register address of the frame |
| bus_byte | input | 1 | Data byte strobe |
| bus_data | input | 8 | Data byte |
| bus_stop | input | 1 | Frame end strobe |
| sys_rst | output | 1 | System reset, active high |
| fault_rd | output | 8 | Reset cause register |

## Verification
The bench measures release delays and watchdog periods down to the exact cycle for several select codes. A counter that is off by one, or that restarts from the wrong event, gives a count one cycle too long or too short. It overlaps two low-voltage flags so that the delay must count only from the last clear. It sends malformed frames: no data byte, two data bytes, the wrong address and the wrong device code. A design that commits on any byte count, or decodes the address only in part, would wipe the captured causes. It loads the register while a rail flag is active, so a design that lets the write override the set loses that cause bit. It also runs a long window with the watchdog switched off, where a decode slip would show up as a spurious reset.

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int unsigned DLY_SEL0 = 2_500_000,
  parameter int unsigned DLY_SEL1 = 10_000_000,
  parameter int unsigned DLY_SEL2 = 20_000_000,
  parameter int unsigned DLY_SEL3 = 40_000_000,
  parameter int unsigned WD_SEL0  = 70_000_000,
  parameter int unsigned WD_SEL1  = 10_000_000,
  parameter int unsigned WD_SEL2  = 1_250_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] lv_flag,
  input  logic       mr_in,
  input  logic       wd_kick,
  input  logic [1:0] pup_sel,
  input  logic [1:0] wd_sel,
  input  logic       bus_start,
  input  logic [3:0] bus_dev,
  input  logic [7:0] bus_addr,
  input  logic       bus_byte,
  input  logic [7:0] bus_data,
  input  logic       bus_stop,
  output logic       sys_rst,
  output logic [7:0] fault_rd
);
  localparam int unsigned DMAX01 = (DLY_SEL0 > DLY_SEL1) ? DLY_SEL0 : DLY_SEL1;
  localparam int unsigned DMAX23 = (DLY_SEL2 > DLY_SEL3) ? DLY_SEL2 : DLY_SEL3;
  localparam int unsigned DMAX   = (DMAX01 > DMAX23) ? DMAX01 : DMAX23;
  localparam int unsigned WMAX01 = (WD_SEL0 > WD_SEL1) ? WD_SEL0 : WD_SEL1;
  localparam int unsigned WMAX   = (WMAX01 > WD_SEL2) ? WMAX01 : WD_SEL2;
  localparam int unsigned CMAX   = (DMAX > WMAX) ? DMAX : WMAX;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [3:0] MY_DEV  = 4'b1011;
  localparam logic [7:0] MY_ADDR = 8'hFF;

  logic [CNT_W-1:0] dly_cnt, wd_cnt, dly_lim, wd_lim;
  logic             rst_q, sel_ok;
  logic [1:0]       byte_cnt;
  logic [4:0]       wbuf, fault_q, set_vec;

  always_comb
    case (pup_sel)
      2'b00:   dly_lim = CNT_W'(DLY_SEL0);
      2'b01:   dly_lim = CNT_W'(DLY_SEL1);
      2'b10:   dly_lim = CNT_W'(DLY_SEL2);
      default: dly_lim = CNT_W'(DLY_SEL3);
    endcase

  always_comb
    case (wd_sel)
      2'b00:   wd_lim = CNT_W'(WD_SEL0);
      2'b01:   wd_lim = CNT_W'(WD_SEL1);
      default: wd_lim = CNT_W'(WD_SEL2);
    endcase

  wire hold      = (|lv_flag) | mr_in;
  wire wd_off    = (wd_sel == 2'b11);
  wire wd_expire = !rst_q && !hold && !wd_off && !wd_kick &&
                   (wd_cnt == wd_lim - CNT_W'(1));
  wire commit    = bus_stop && sel_ok && (byte_cnt == 2'd1);

  assign set_vec  = {lv_flag[0], lv_flag[1], lv_flag[2], wd_expire, mr_in};
  assign sys_rst  = rst_q;
  assign fault_rd = {fault_q, 3'b000};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_q   <= 1'b1;
      dly_cnt <= '0;
      wd_cnt  <= '0;
    end else if (hold) begin
      rst_q   <= 1'b1;
      dly_cnt <= '0;
      wd_cnt  <= '0;
    end else if (rst_q) begin
      wd_cnt <= '0;
      if (dly_cnt == dly_lim - CNT_W'(1)) begin
        rst_q   <= 1'b0;
        dly_cnt <= '0;
      end else begin
        dly_cnt <= dly_cnt + CNT_W'(1);
      end
    end else if (wd_off || wd_kick) begin
      wd_cnt <= '0;
    end else if (wd_expire) begin
      rst_q   <= 1'b1;
      wd_cnt  <= '0;
      dly_cnt <= '0;
    end else begin
      wd_cnt <= wd_cnt + CNT_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_ok   <= 1'b0;
      byte_cnt <= 2'd0;
      wbuf     <= '0;
    end else if (bus_start) begin
      sel_ok   <= (bus_dev == MY_DEV) && (bus_addr == MY_ADDR);
      byte_cnt <= 2'd0;
    end else if (bus_byte) begin
      if (byte_cnt == 2'd0) wbuf <= bus_data[7:3];
      if (byte_cnt != 2'd2) byte_cnt <= byte_cnt + 2'd1;
    end else if (bus_stop) begin
      sel_ok <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fault_q <= '0;
    else        fault_q <= (commit ? wbuf : fault_q) | set_vec;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|lv_flag) |=> sys_rst);
  assert_mr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mr_in |=> (sys_rst && fault_rd[3]));
  assert_release_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> !$past(hold));
  assert_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (sys_rst && fault_rd[4]));
  assert_lv_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lv_flag[0] |=> fault_rd[7]);
  assert_wd_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_off && !sys_rst && !hold) |=> !sys_rst);
  assert_bad_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && byte_cnt != 2'd1) |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
endmodule

// File: tb/reset_supervisor_test.sv
module reset_supervisor_test;
  localparam int D0 = 5, D1 = 8, D2 = 11, D3 = 14;
  localparam int W0 = 20, W1 = 12, W2 = 7;

  logic clk = 0, rst_n = 0;
  logic [2:0] lv_flag = 0;
  logic mr_in = 0, wd_kick = 0;
  logic [1:0] pup_sel = 2'b01, wd_sel = 2'b11;
  logic bus_start = 0, bus_byte = 0, bus_stop = 0;
  logic [3:0] bus_dev = 0;
  logic [7:0] bus_addr = 0, bus_data = 0;
  logic sys_rst;
  logic [7:0] fault_rd;

  int nchk = 0, nfail = 0;
  string ph = "R1";

  reset_supervisor #(.DLY_SEL0(D0), .DLY_SEL1(D1), .DLY_SEL2(D2), .DLY_SEL3(D3),
                     .WD_SEL0(W0), .WD_SEL1(W1), .WD_SEL2(W2)) uut (
    .clk(clk), .rst_n(rst_n), .lv_flag(lv_flag), .mr_in(mr_in), .wd_kick(wd_kick),
    .pup_sel(pup_sel), .wd_sel(wd_sel), .bus_start(bus_start), .bus_dev(bus_dev),
    .bus_addr(bus_addr), .bus_byte(bus_byte), .bus_data(bus_data), .bus_stop(bus_stop),
    .sys_rst(sys_rst), .fault_rd(fault_rd));

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_rst = 1, m_dly = 0, m_wd = 0, m_fault = 0, m_n = 0, m_wbuf = 0;
  bit m_sel = 0;
  function automatic int dly_of(logic [1:0] s);
    int t[4] = '{D0, D1, D2, D3};
    return t[s];
  endfunction
  function automatic int wd_of(logic [1:0] s);
    int t[4] = '{W0, W1, W2, 0};
    return t[s];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rst = 1; m_dly = 0; m_wd = 0; m_fault = 0; m_n = 0; m_sel = 0; m_wbuf = 0;
    end else begin
      bit tout = 0;
      int nf = m_fault;
      if (lv_flag != 0 || mr_in) begin
        m_rst = 1; m_dly = 0; m_wd = 0;
      end else if (m_rst == 1) begin
        m_wd = 0; m_dly++;
        if (m_dly == dly_of(pup_sel)) begin m_rst = 0; m_dly = 0; end
      end else if (wd_sel == 2'b11 || wd_kick) begin
        m_wd = 0;
      end else begin
        m_wd++;
        if (m_wd == wd_of(wd_sel)) begin m_rst = 1; m_wd = 0; m_dly = 0; tout = 1; end
      end
      if (bus_stop && m_sel && m_n == 1) nf = m_wbuf & 'hF8;
      if (lv_flag[0]) nf |= 'h80;
      if (lv_flag[1]) nf |= 'h40;
      if (lv_flag[2]) nf |= 'h20;
      if (tout)       nf |= 'h10;
      if (mr_in)      nf |= 'h08;
      m_fault = nf;
      if (bus_start) begin
        m_sel = (bus_dev == 4'b1011 && bus_addr == 8'hFF); m_n = 0;
      end else if (bus_byte) begin
        if (m_n == 0) m_wbuf = bus_data;
        m_n++;
      end else if (bus_stop) m_sel = 0;
    end
  end

  always @(negedge clk) begin
    chk({ph, " model sys_rst"}, int'(sys_rst), m_rst);
    chk({ph, " model fault_rd"}, int'(fault_rd), m_fault);
  end

  task automatic measure_rst(output int n);
    n = 0;
    while (sys_rst && n < 1000) begin @(negedge clk); n++; end
  endtask
  task automatic measure_low(output int n);
    n = 0;
    while (!sys_rst && n < 1000) begin n++; @(negedge clk); end
  endtask
  task automatic frame(logic [3:0] d, logic [7:0] a, int nb, logic [7:0] data);
    bus_dev = d; bus_addr = a; bus_start = 1;
    @(negedge clk); bus_start = 0;
    for (int i = 0; i < nb; i++) begin
      bus_byte = 1; bus_data = data; @(negedge clk); bus_byte = 0;
    end
    bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    chk("R1 reset sys_rst", int'(sys_rst), 1);
    chk("R1 reset fault_rd", int'(fault_rd), 0);
    rst_n = 1;
    measure_rst(n); chk("R1 power-up delay code 01", n, D1);

    ph = "R2"; pup_sel = 2'b00;
    lv_flag = 3'b010; @(negedge clk); lv_flag = 0;
    measure_rst(n); chk("R2 delay code 00", n, D0);
    chk("R7 lv2 bit6", int'(fault_rd), 'h40);
    frame(4'b1011, 8'hFF, 1, 8'h00);
    chk("R8 clear by write", int'(fault_rd), 0);
    lv_flag = 3'b001; repeat (3) @(negedge clk);
    lv_flag = 3'b101; repeat (3) @(negedge clk);
    lv_flag = 3'b100; repeat (3) @(negedge clk);
    lv_flag = 0;
    measure_rst(n); chk("R2 delay from last clear", n, D0);
    chk("R7 lv1 and lv3 bits", int'(fault_rd), 'hA0);
    frame(4'b1011, 8'hFF, 1, 8'h00);

    ph = "R3"; pup_sel = 2'b10; mr_in = 1;
    seen = 0;
    repeat (10) begin @(negedge clk); if (!sys_rst) seen = 1; end
    chk("R3 held by manual reset", int'(seen), 0);
    mr_in = 0;
    measure_rst(n); chk("R3 delay code 10", n, D2);
    chk("R7 mr bit3", int'(fault_rd), 'h08);

    ph = "R8";
    frame(4'b1011, 8'hFF, 2, 8'h00); chk("R8 two bytes ignored", int'(fault_rd), 'h08);
    frame(4'b1011, 8'hFE, 1, 8'h00); chk("R8 wrong address ignored", int'(fault_rd), 'h08);
    frame(4'b1010, 8'hFF, 1, 8'h00); chk("R8 wrong device ignored", int'(fault_rd), 'h08);
    frame(4'b1011, 8'hFF, 0, 8'h00); chk("R8 no byte ignored", int'(fault_rd), 'h08);
    frame(4'b1011, 8'hFF, 1, 8'hFF); chk("R7 low bits read zero", int'(fault_rd), 'hF8);
    frame(4'b1011, 8'hFF, 1, 8'h00); chk("R8 clear", int'(fault_rd), 0);
    lv_flag = 3'b100;
    frame(4'b1011, 8'hFF, 1, 8'h00); chk("R8 set wins over load", int'(fault_rd), 'h20);
    lv_flag = 0;
    measure_rst(n); chk("R2 delay code 10", n, D2);
    frame(4'b1011, 8'hFF, 1, 8'h00);

    ph = "R4"; wd_sel = 2'b10;
    measure_low(n); chk("R4 period code 10", n, W2);
    chk("R7 wdf bit4", int'(fault_rd), 'h10);
    ph = "R6";
    measure_rst(n); chk("R6 timeout reset length", n, D2);
    measure_low(n); chk("R6 watchdog restarts", n, W2);
    measure_rst(n);

    ph = "R5"; seen = 0;
    repeat (10) begin
      wd_kick = 1; @(negedge clk); wd_kick = 0;
      if (sys_rst) seen = 1;
      repeat (4) begin @(negedge clk); if (sys_rst) seen = 1; end
    end
    chk("R5 kicks prevent timeout", int'(seen), 0);

    ph = "R4"; wd_sel = 2'b00; wd_kick = 1; @(negedge clk); wd_kick = 0;
    measure_low(n); chk("R4 period code 00", n, W0);
    measure_rst(n);

    ph = "R9"; wd_sel = 2'b11; seen = 0;
    repeat (60) begin @(negedge clk); if (sys_rst) seen = 1; end
    chk("R9 disabled watchdog", int'(seen), 0);

    ph = "R4"; wd_sel = 2'b01;
    measure_low(n); chk("R4 period code 01", n, W1);
    measure_rst(n);
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule